// File: doc/BRIEF.md
# Synchronous Rectifier Gate Controller

This block decides when the gate of a secondary-side synchronous-rectifier switch is on. It reads three digital flags, each the output of an external comparator watching the switch's drain-source voltage against its own threshold. The first flag is the turn-on flag. It is high while the voltage sits further negative than the turn-on level, which shows that the body diode is conducting. The second is the turn-off flag. It is high while the magnitude of the voltage has decayed to the turn-off level or below. The third is the re-arm flag. It is high once the voltage has risen past the re-arm level.

Every flag passes through a two-flop synchronizer. A crossing is a 0-to-1 change of the synchronized flag. A turn-on crossing while idle switches the gate on. After that, a minimum on-time masks the turn-off flag, so that ringing at turn-on cannot end conduction early. Once the mask expires, the turn-off flag switches the gate off. This works both when the current decays slowly and when the primary switch forces it down quickly. The gate then stays off through a blanking state, so that the voltage snap from residual body-diode current is not taken as a new turn-on. Blanking ends only on a re-arm crossing.

Top module: `sr_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with all flags low, `gateOn` is 0 and `ctrlState` is 0 (idle).
- R2: In idle, a 0-to-1 change of `onCmpIn` drives `gateOn` to 1 and `ctrlState` to 1 (masked on-time). The change is visible after the third rising clock edge following the input change.
- R3: In idle, a turn-on flag that is held high without a fresh 0-to-1 change does not turn the gate on.
- R4: From the first cycle with `gateOn` high until `MIN_ON_CYCLES` cycles have elapsed, `offCmpIn` has no effect: the gate stays high and `ctrlState` stays 1.
- R5: If the synchronized turn-off flag is high when the minimum on-time ends, `gateOn` falls exactly `MIN_ON_CYCLES` cycles after it rose, and `ctrlState` becomes 3 (blanking).
- R6: If the turn-off flag is low when the mask ends, `ctrlState` becomes 2 (armed) with the gate still on. A later rise of `offCmpIn` drops `gateOn` and sets `ctrlState` to 3 on the third rising edge after the change.
- R7: In blanking, turn-on crossings are ignored: `gateOn` stays 0 and `ctrlState` stays 3 until a re-arm crossing.
- R8: In blanking, a 0-to-1 change of `rearmCmpIn` returns `ctrlState` to 0 on the third rising edge after the change, with the gate still off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| onCmpIn | input | 1 | Turn-on comparator flag, 1 when the voltage is more negative than the turn-on level |
| offCmpIn | input | 1 | Turn-off comparator flag, 1 when the voltage magnitude is at or below the turn-off level |
| rearmCmpIn | input | 1 | Re-arm comparator flag, 1 when the voltage is above the re-arm level |
| gateOn | output | 1 | Registered gate enable |
| ctrlState | output | 2 | 0 idle, 1 masked on-time, 2 armed on-time, 3 blanking |

## Verification
The synchronizer takes two edges. The edge detector and the registered state add one more. So every reaction to a flag change is due on the third rising edge after the change. The exception is the end of the mask: there the gate falls on the edge counted from its own rise, `MIN_ON_CYCLES` later.

Each stimulus row is applied just after a falling edge. The bench then waits a stated number of rising edges and samples at the next falling edge. Row lengths are chosen so that each sample lands either one edge before or exactly on the edge where a transition is due. This exposes both early and late reactions.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

  localparam int NUM_CMP   = 3;
  localparam int CMP_ON    = 0;
  localparam int CMP_OFF   = 1;
  localparam int CMP_REARM = 2;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ON_MASKED = 2'd1,
    ST_ON_ARMED  = 2'd2,
    ST_BLANK     = 2'd3
  } srState_e;

  // events from datapath to control
  typedef struct packed {
    logic onRise;
    logic offLevel;
    logic rearmRise;
    logic minOnDone;
  } cmpEvents_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearTimer;
  } ctrlStrobes_t;

endpackage

// File: rtl/sr_gate_datapath.sv
module sr_gate_datapath
  import sr_gate_pkg::*;
#(
  parameter int MIN_ON_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CMP-1:0]  rawFlags,
  input  ctrlStrobes_t        strobes,
  output cmpEvents_t          events
);

  localparam int CNT_W = (MIN_ON_CYCLES < 2) ? 1 : $clog2(MIN_ON_CYCLES + 1);
  localparam logic [CNT_W-1:0] TIMER_LAST = CNT_W'(MIN_ON_CYCLES - 1);

  logic [NUM_CMP-1:0] syncFlags;
  logic [NUM_CMP-1:0] prevFlags;
  logic [NUM_CMP-1:0] riseFlags;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CMP; gi++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawFlags[gi]};
      end
      assign syncFlags[gi] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevFlags <= '0;
    else       prevFlags <= syncFlags;
  end

  assign riseFlags = syncFlags & ~prevFlags;

  logic [CNT_W-1:0] onTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    onTimer <= TIMER_LAST;
    else if (strobes.clearTimer)  onTimer <= '0;
    else if (onTimer < TIMER_LAST) onTimer <= onTimer + 1'b1;
  end

  always_comb begin
    events.onRise    = riseFlags[CMP_ON];
    events.offLevel  = syncFlags[CMP_OFF];
    events.rearmRise = riseFlags[CMP_REARM];
    events.minOnDone = (onTimer == TIMER_LAST);
  end

endmodule

// File: rtl/sr_gate_control.sv
module sr_gate_control
  import sr_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  cmpEvents_t   events,
  output ctrlStrobes_t strobes,
  output srState_e     curState,
  output logic         gateReg
);

  srState_e nextState;

  always_comb begin
    nextState          = curState;
    strobes.clearTimer = 1'b0;
    unique case (curState)
      ST_IDLE: begin
        if (events.onRise) begin
          nextState          = ST_ON_MASKED;
          strobes.clearTimer = 1'b1;
        end
      end
      ST_ON_MASKED: begin
        if (events.minOnDone)
          nextState = events.offLevel ? ST_BLANK : ST_ON_ARMED;
      end
      ST_ON_ARMED: begin
        if (events.offLevel) nextState = ST_BLANK;
      end
      ST_BLANK: begin
        if (events.rearmRise) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      gateReg  <= 1'b0;
    end else begin
      curState <= nextState;
      gateReg  <= (nextState == ST_ON_MASKED) || (nextState == ST_ON_ARMED);
    end
  end

endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_gate_pkg::*;
#(
  parameter int MIN_ON_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       onCmpIn,
  input  logic       offCmpIn,
  input  logic       rearmCmpIn,
  output logic       gateOn,
  output logic [1:0] ctrlState
);

  cmpEvents_t         events;
  ctrlStrobes_t       strobes;
  srState_e           curState;
  logic [NUM_CMP-1:0] rawFlags;

  always_comb begin
    rawFlags            = '0;
    rawFlags[CMP_ON]    = onCmpIn;
    rawFlags[CMP_OFF]   = offCmpIn;
    rawFlags[CMP_REARM] = rearmCmpIn;
  end

  sr_gate_datapath #(
    .MIN_ON_CYCLES (MIN_ON_CYCLES),
    .SYNC_STAGES   (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rawFlags (rawFlags),
    .strobes  (strobes),
    .events   (events)
  );

  sr_gate_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .events   (events),
    .strobes  (strobes),
    .curState (curState),
    .gateReg  (gateOn)
  );

  assign ctrlState = curState;

endmodule

// File: rtl/sr_gate_ctrl_chk.sv
module sr_gate_ctrl_chk #(
  parameter int MIN_ON_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       gateOn,
  input logic [1:0] ctrlState
);

  localparam int RUN_W = $clog2(MIN_ON_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_ON_CYCLES + 1);

  logic [RUN_W-1:0] onRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               onRun <= '0;
    else if (!gateOn)        onRun <= '0;
    else if (onRun < RUN_MAX) onRun <= onRun + 1'b1;
  end

  assert_idle_gate_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 2'd0) |-> !gateOn);

  assert_rise_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> (ctrlState == 2'd1) && ($past(ctrlState) == 2'd0));

  assert_min_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> (onRun >= RUN_W'(MIN_ON_CYCLES)));

  assert_fall_to_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> (ctrlState == 2'd3));

  assert_blank_no_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 2'd3) |=> !gateOn);

  assert_leave_blank_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlState) == 2'd3 && ctrlState != 2'd3) |-> (ctrlState == 2'd0));

endmodule

bind sr_gate_ctrl sr_gate_ctrl_chk #(.MIN_ON_CYCLES(MIN_ON_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gateOn    (gateOn),
  .ctrlState (ctrlState)
);

// File: tb/sr_gate_ctrl_tb.sv
module sr_gate_ctrl_tb;

  localparam int MIN_ON = 6;
  localparam int NROWS  = 18;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       onCmpIn = 1'b0;
  logic       offCmpIn = 1'b0;
  logic       rearmCmpIn = 1'b0;
  logic       gateOn;
  logic [1:0] ctrlState;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  sr_gate_ctrl #(.MIN_ON_CYCLES(MIN_ON)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .onCmpIn    (onCmpIn),
    .offCmpIn   (offCmpIn),
    .rearmCmpIn (rearmCmpIn),
    .gateOn     (gateOn),
    .ctrlState  (ctrlState)
  );

  // row: {on,off,rearm}[9:7], edges to wait [6:3], expected gate [2], expected state [1:0]
  localparam logic [9:0] VEC [NROWS] = '{
    {3'b000, 4'd3, 1'b0, 2'd0},  // R1 idle at rest
    {3'b100, 4'd3, 1'b1, 2'd1},  // R2 turn-on crossing
    {3'b110, 4'd2, 1'b1, 2'd1},  // R4 off flag rises during mask
    {3'b010, 4'd3, 1'b1, 2'd1},  // R4 still masked one edge before end
    {3'b010, 4'd1, 1'b0, 2'd3},  // R5 forced minimum duty, drop on mask end
    {3'b110, 4'd4, 1'b0, 2'd3},  // R7 snap crossing in blanking ignored
    {3'b011, 4'd2, 1'b0, 2'd3},  // R8 re-arm not yet through sync
    {3'b011, 4'd1, 1'b0, 2'd0},  // R8 re-arm returns to idle
    {3'b001, 4'd3, 1'b0, 2'd0},  // R3 idle stays idle
    {3'b101, 4'd3, 1'b1, 2'd1},  // R2 second turn-on
    {3'b100, 4'd6, 1'b1, 2'd2},  // R6 mask ends with off low, armed
    {3'b110, 4'd2, 1'b1, 2'd2},  // R6 off rise not yet effective
    {3'b110, 4'd1, 1'b0, 2'd3},  // R6 turn-off on third edge
    {3'b100, 4'd5, 1'b0, 2'd3},  // R7 blanking holds without re-arm
    {3'b101, 4'd3, 1'b0, 2'd0},  // R8 re-arm with on flag held high
    {3'b101, 4'd4, 1'b0, 2'd0},  // R3 held on flag gives no turn-on
    {3'b001, 4'd3, 1'b0, 2'd0},  // R3 on flag released
    {3'b101, 4'd3, 1'b1, 2'd1}   // R2 fresh crossing turns on
  };

  task automatic check(input string req, input logic expGate, input logic [1:0] expState);
    checkCount++;
    if (gateOn !== expGate || ctrlState !== expState) begin
      failCount++;
      $display("FAIL %s: gateOn=%b ctrlState=%0d expected gateOn=%b ctrlState=%0d",
               req, gateOn, ctrlState, expGate, expState);
    end
  endtask

  initial begin
    #200000;
    failCount++;
    checkCount++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < NROWS; r++) begin
      onCmpIn    = VEC[r][9];
      offCmpIn   = VEC[r][8];
      rearmCmpIn = VEC[r][7];
      repeat (int'(VEC[r][6:3])) @(posedge clk);
      @(negedge clk);
      check($sformatf("row %0d", r), VEC[r][2], VEC[r][1:0]);
    end
    // R1: asynchronous reset while the gate is on
    rstN = 1'b0;
    #1;
    check("R1 reset while on", 1'b0, 2'd0);
    onCmpIn = 1'b0; offCmpIn = 1'b0; rearmCmpIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 after release", 1'b0, 2'd0);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule